// File: doc/BRIEF.md
# Method Address Emit Unit

This unit is the write-back stage of a small macro engine that turns short programs into a stream of command-method writes. For each instruction it receives a 3-bit assign code, a destination register index and the ALU result. From these it decides what goes back into the destination register: the ALU result, or the next word popped from the parameter source. It also decides whether the result becomes the new method address, and which word, if any, goes out as a method write.

The unit keeps a 14-bit byte method address, an auto-increment step and a flag that shows whether any address has been set. When an address is set, the byte address is the low 12 bits of the value times four, and the step is taken from bits [15:12] of the same value. Every method write that goes out carries the current address and then moves the address forward by four times the step. An instruction that needs a parameter word waits until the parameter source offers one.

Top module: `method_emit_unit`

## Requirements
- R1: After a synchronous reset, `wb_valid` and `mth_valid` are low and no method address is set.
- R2: Setting an address loads the byte address with `{value[11:0], 2'b00}` and the step with `value[15:12]`.
- R3: Each method write presents the current address with its data word. After the write, the address advances by step*4, modulo 2^14.
- R4: An emit request made while no address has ever been set produces no method write. The instruction still completes its register write-back.
- R5: Code 0 writes the popped parameter word to the destination. Code 1 writes the ALU result. Neither code sets an address or emits.
- R6: Codes 2 and 5 both write the ALU result to the destination and set the method address from it, with no emit and no parameter pop.
- R7: Code 3 writes the popped parameter word to the destination and emits the ALU result. Code 4 writes the ALU result to the destination and emits it.
- R8: Code 6 writes the ALU result to the destination and sets the address from it. It then emits the popped parameter word at the newly set address, after which the address advances.
- R9: Code 7 writes the ALU result to the destination and sets the address from it. It then emits `result[17:12]`, zero-extended, at the new address.
- R10: Codes 0, 3 and 6 pop one parameter. Such an instruction is accepted (`op_ready` high) only while `par_valid` is high. Codes that need no parameter are accepted at once and never assert `par_ready`.
- R11: `wb_valid` and `mth_valid` are registered. They rise in the cycle after an instruction is accepted and last for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction write-back request |
| op_ready | output | 1 | Instruction accepted this cycle when high with op_valid |
| op_code | input | 3 | Assign code |
| op_dst | input | 3 | Destination register index |
| op_result | input | 32 | ALU result for this instruction |
| par_valid | input | 1 | Parameter word available |
| par_ready | output | 1 | Parameter word is popped when high with par_valid |
| par_data | input | 32 | Parameter word |
| wb_valid | output | 1 | Register write-back strobe |
| wb_dst | output | 3 | Register write-back index |
| wb_data | output | 32 | Register write-back value |
| mth_valid | output | 1 | Method write strobe |
| mth_addr | output | 14 | Method byte address |
| mth_data | output | 32 | Method data word |

## Verification
The bench goes after the emit that comes before any address is set. A design that got this wrong would emit at a stale address of zero instead of staying silent. It also checks the set-and-emit codes. A design that used the old address there, or forgot to advance the address after the emit, would misplace every later write in the run. Steps of 0 and 15 near the top of the address space show whether the increment wraps at 14 bits or spills into extra bits. Code 5 and the stall case show whether the design pops a parameter it must not take, or accepts an instruction while the parameter source is empty.

// File: rtl/method_emit_pkg.sv
package method_emit_pkg;

  typedef enum logic [2:0] {
    ASG_PARAM          = 3'd0,
    ASG_RESULT         = 3'd1,
    ASG_RESULT_ADDR    = 3'd2,
    ASG_PARAM_EMITRES  = 3'd3,
    ASG_RESULT_EMIT    = 3'd4,
    ASG_RESULT_ADDR_B  = 3'd5,
    ASG_ADDR_EMITPARAM = 3'd6,
    ASG_ADDR_EMITHIGH  = 3'd7
  } asg_code_e;

  typedef enum logic [1:0] {
    EMIT_NONE   = 2'd0,
    EMIT_RESULT = 2'd1,
    EMIT_PARAM  = 2'd2,
    EMIT_HIGH   = 2'd3
  } emit_src_e;

  typedef struct packed {
    logic      pop_param;
    logic      wb_from_param;
    logic      set_addr;
    emit_src_e emit_src;
  } asg_ctrl_t;

endpackage

// File: rtl/method_assign_decode.sv
module method_assign_decode
  import method_emit_pkg::*;
(
  input  logic [2:0] code,
  output asg_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{pop_param: 1'b0, wb_from_param: 1'b0, set_addr: 1'b0, emit_src: EMIT_NONE};
    case (asg_code_e'(code))
      ASG_PARAM: begin
        ctrl.pop_param     = 1'b1;
        ctrl.wb_from_param = 1'b1;
      end
      ASG_RESULT: begin
      end
      ASG_RESULT_ADDR, ASG_RESULT_ADDR_B: begin
        ctrl.set_addr = 1'b1;
      end
      ASG_PARAM_EMITRES: begin
        ctrl.pop_param     = 1'b1;
        ctrl.wb_from_param = 1'b1;
        ctrl.emit_src      = EMIT_RESULT;
      end
      ASG_RESULT_EMIT: begin
        ctrl.emit_src = EMIT_RESULT;
      end
      ASG_ADDR_EMITPARAM: begin
        ctrl.pop_param = 1'b1;
        ctrl.set_addr  = 1'b1;
        ctrl.emit_src  = EMIT_PARAM;
      end
      ASG_ADDR_EMITHIGH: begin
        ctrl.set_addr = 1'b1;
        ctrl.emit_src = EMIT_HIGH;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/method_addr_track.sv
module method_addr_track #(
  parameter int IDX_W  = 12,
  parameter int STEP_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en,
  input  logic [IDX_W+STEP_W-1:0] set_val,
  input  logic                  emit_req,
  output logic                  emit_fire,
  output logic [IDX_W+1:0]      emit_addr,
  output logic                  has_addr
);

  localparam int ADDR_W = IDX_W + 2;
  localparam int PAD_W  = ADDR_W - STEP_W - 2;

  logic [ADDR_W-1:0] addr_q;
  logic [STEP_W-1:0] step_q;
  logic              has_q;

  logic [ADDR_W-1:0] eff_addr;
  logic [STEP_W-1:0] eff_step;
  logic              eff_has;
  logic [ADDR_W-1:0] eff_inc;

  always_comb begin
    eff_addr  = set_en ? {set_val[IDX_W-1:0], 2'b00} : addr_q;
    eff_step  = set_en ? set_val[IDX_W +: STEP_W] : step_q;
    eff_has   = set_en | has_q;
    eff_inc   = {{PAD_W{1'b0}}, eff_step, 2'b00};
    emit_fire = emit_req & eff_has;
    emit_addr = eff_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      step_q <= '0;
      has_q  <= 1'b0;
    end else begin
      has_q  <= eff_has;
      step_q <= eff_step;
      addr_q <= emit_fire ? eff_addr + eff_inc : eff_addr;
    end
  end

  assign has_addr = has_q;

  assert_no_emit_unset_R4: assert property (@(posedge clk) disable iff (rst)
    (!has_q && !set_en) |-> !emit_fire);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    has_q |=> has_q);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !emit_fire) |=> (addr_q == $past(addr_q)));

  assert_addr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    emit_fire |=> (addr_q == $past(emit_addr) + {{PAD_W{1'b0}}, step_q, 2'b00}));

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (set_en && !emit_req) |=> (addr_q == {$past(set_val[IDX_W-1:0]), 2'b00}));

endmodule

// File: rtl/method_emit_unit.sv
module method_emit_unit
  import method_emit_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int REG_W    = 3,
  parameter int IDX_W    = 12,
  parameter int STEP_W   = 4,
  parameter int HIGH_LSB = 12,
  parameter int HIGH_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [REG_W-1:0]  op_dst,
  input  logic [DATA_W-1:0] op_result,
  input  logic              par_valid,
  output logic              par_ready,
  input  logic [DATA_W-1:0] par_data,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_data,
  output logic              mth_valid,
  output logic [IDX_W+1:0]  mth_addr,
  output logic [DATA_W-1:0] mth_data
);

  localparam int ADDR_W = IDX_W + 2;
  localparam int SET_W  = IDX_W + STEP_W;

  asg_ctrl_t         ctrl;
  logic              op_fire;
  logic              emit_fire;
  logic [ADDR_W-1:0] emit_addr;
  logic              has_addr;
  logic [DATA_W-1:0] emit_data;
  logic [DATA_W-1:0] wb_next;

  method_assign_decode u_decode (
    .code (op_code),
    .ctrl (ctrl)
  );

  assign op_ready  = !ctrl.pop_param || par_valid;
  assign par_ready = op_valid && ctrl.pop_param;
  assign op_fire   = op_valid && op_ready;

  method_addr_track #(
    .IDX_W  (IDX_W),
    .STEP_W (STEP_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .set_en    (op_fire && ctrl.set_addr),
    .set_val   (op_result[SET_W-1:0]),
    .emit_req  (op_fire && (ctrl.emit_src != EMIT_NONE)),
    .emit_fire (emit_fire),
    .emit_addr (emit_addr),
    .has_addr  (has_addr)
  );

  always_comb begin
    case (ctrl.emit_src)
      EMIT_PARAM: emit_data = par_data;
      EMIT_HIGH:  emit_data = {{(DATA_W-HIGH_W){1'b0}}, op_result[HIGH_LSB +: HIGH_W]};
      default:    emit_data = op_result;
    endcase
    wb_next = ctrl.wb_from_param ? par_data : op_result;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid  <= 1'b0;
      wb_dst    <= '0;
      wb_data   <= '0;
      mth_valid <= 1'b0;
      mth_addr  <= '0;
      mth_data  <= '0;
    end else begin
      wb_valid  <= op_fire;
      mth_valid <= emit_fire;
      if (op_fire) begin
        wb_dst  <= op_dst;
        wb_data <= wb_next;
      end
      if (emit_fire) begin
        mth_addr <= emit_addr;
        mth_data <= emit_data;
      end
    end
  end

  assert_wb_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
    op_fire |=> wb_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !op_fire |=> (!wb_valid && !mth_valid));

  assert_emit_with_wb_R11: assert property (@(posedge clk) disable iff (rst)
    mth_valid |-> wb_valid);

  assert_emit_needs_addr_R4: assert property (@(posedge clk) disable iff (rst)
    mth_valid |-> has_addr);

endmodule

// File: tb/method_emit_unit_tb.sv
module method_emit_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = '0;
  logic [2:0]  op_dst = '0;
  logic [31:0] op_result = '0;
  logic        par_valid = 1'b0;
  logic        par_ready;
  logic [31:0] par_data = '0;
  logic        wb_valid;
  logic [2:0]  wb_dst;
  logic [31:0] wb_data;
  logic        mth_valid;
  logic [13:0] mth_addr;
  logic [31:0] mth_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [13:0] m_addr = '0;
  logic [3:0]  m_step = '0;
  bit          m_has  = 1'b0;

  always #10 clk = ~clk;

  method_emit_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_dst(op_dst), .op_result(op_result),
    .par_valid(par_valid), .par_ready(par_ready), .par_data(par_data),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
    .mth_valid(mth_valid), .mth_addr(mth_addr), .mth_data(mth_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string code_req(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return "R5";
      3'd2, 3'd5: return "R6";
      3'd3, 3'd4: return "R7";
      3'd6:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] c, input logic [2:0] d,
                        input logic [31:0] res, input logic [31:0] prm);
    bit need, set, emit, exp_mv;
    logic [31:0] wbd, ed;
    logic [13:0] exp_ma;
    string rq;
    rq   = code_req(c);
    need = (c == 3'd0) || (c == 3'd3) || (c == 3'd6);
    set  = (c == 3'd2) || (c == 3'd5) || (c == 3'd6) || (c == 3'd7);
    emit = (c == 3'd3) || (c == 3'd4) || (c == 3'd6) || (c == 3'd7);
    wbd  = ((c == 3'd0) || (c == 3'd3)) ? prm : res;
    ed   = (c == 3'd6) ? prm : (c == 3'd7) ? {26'd0, res[17:12]} : res;
    if (set) begin
      m_addr = {res[11:0], 2'b00};
      m_step = res[15:12];
      m_has  = 1'b1;
    end
    exp_mv = emit && m_has;
    exp_ma = m_addr;
    if (exp_mv) m_addr = m_addr + {8'd0, m_step, 2'b00};

    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_dst = d; op_result = res;
    par_valid = need; par_data = prm;
    #2;
    check("R10", "op_ready", {31'd0, op_ready}, 32'd1);
    check("R10", "par_ready", {31'd0, par_ready}, {31'd0, need});
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; par_valid = 1'b0;
    check(rq, "wb_valid", {31'd0, wb_valid}, 32'd1);
    check(rq, "wb_dst", {29'd0, wb_dst}, {29'd0, d});
    check(rq, "wb_data", wb_data, wbd);
    check(m_has ? rq : "R4", "mth_valid", {31'd0, mth_valid}, {31'd0, exp_mv});
    if (exp_mv) begin
      check("R2/R3", "mth_addr", {18'd0, mth_addr}, {18'd0, exp_ma});
      check(rq, "mth_data", mth_data, ed);
    end
    @(negedge clk);
    check("R11", "wb pulse", {30'd0, wb_valid, mth_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
    check("R1", "mth_valid after reset", {31'd0, mth_valid}, 32'd0);

    // R4: emits before any address is set
    run_op(3'd4, 3'd1, 32'h0000_1234, 32'h0);
    run_op(3'd3, 3'd2, 32'h0000_5678, 32'hCAFE_0001);
    run_op(3'd1, 3'd3, 32'h1111_2222, 32'h0);

    // sweep over codes and spread values
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 12; i++) begin
        logic [31:0] v, p;
        v = (32'h9E37_79B9 * (i + 1)) ^ (32'h0101_0101 * c);
        p = 32'h7F4A_7C15 * (i + 3) + c;
        run_op(c[2:0], 3'(i), v, p);
        run_op(3'd4, 3'(c), p, 32'h0);
      end
    end

    // R3 wrap: address near top of space, step 15
    run_op(3'd2, 3'd1, 32'h0000_FFFF, 32'h0);
    for (int k = 0; k < 6; k++) run_op(3'd4, 3'd2, 32'hA000_0000 + k, 32'h0);
    // step 0 keeps the address
    run_op(3'd5, 3'd1, 32'h0000_0ABC, 32'h0);
    for (int k = 0; k < 3; k++) run_op(3'd4, 3'd2, 32'hB000_0000 + k, 32'h0);
    // R8 and R9 directed values
    run_op(3'd6, 3'd4, 32'h0000_2010, 32'hDEAD_BEEF);
    run_op(3'd3, 3'd5, 32'h0000_0042, 32'h1234_5678);
    run_op(3'd7, 3'd6, 32'h0003_F123, 32'h0);
    run_op(3'd7, 3'd6, 32'hFFFC_0FFF, 32'h0);

    // R10 stall: parameter source empty
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd0; op_dst = 3'd7; op_result = 32'h5;
    par_valid = 1'b0; par_data = 32'h0BAD_F00D;
    #2;
    check("R10", "op_ready stalled", {31'd0, op_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R10", "no wb while stalled", {31'd0, wb_valid}, 32'd0);
    par_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; par_valid = 1'b0;
    check("R10", "wb after param arrives", {31'd0, wb_valid}, 32'd1);
    check("R5", "wb_data param", wb_data, 32'h0BAD_F00D);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule